// File: doc/BRIEF.md
# Fractional-Rate Interpolating Sample Stepper

This block sits between an ADPCM-style nibble decoder and a fixed-rate audio output. On every output tick it adds a programmable step to a phase register that carries 16 fractional bits. The integer part of that sum tells the decoder how many nibbles to consume before the next tick; only the fraction is kept. From the decoder's previous and current samples it forms a linear interpolation weighted by the phase fraction, scales the result by an 8-bit linear volume, and sends it to the left output, the right output, both, or neither according to two pan bits.

Settings come through a small byte-wide write port. Two writes form the 16-bit step (low byte, high byte). A third write sets the volume. A fourth sets the control byte, whose top two bits carry the pan enables. A start strobe clears the phase at the beginning of playback. The decoder must finish the requested nibbles and present updated samples before the next tick.

Top module: `frac_rate_stepper`

## Requirements
- R1: After reset the phase, step and volume are 0, both pan enables are 1, `req_vld` is 0, and both outputs are 0.
- R2: A write with `cfg_sel`=0 loads the low byte of the step and `cfg_sel`=1 loads its high byte. The step is {high, low}.
- R3: A tick (with `start` low) replaces the phase with the low 16 bits of phase+step. On the next cycle `req_vld` is 1 for one cycle and `req_cnt` carries the integer part (bits above 15) of that sum.
- R4: `start` sets the phase to 0. When it coincides with a tick, `start` wins: no request is issued and the outputs do not update for that tick.
- R5: For a tick whose pre-update phase fraction is f, the interpolated value is floor((prev·(65536−f) + cur·f) / 65536). Here prev and cur are the signed sample inputs sampled at that tick, and the value lies between them.
- R6: The interpolated value is multiplied by the volume (`cfg_sel`=2, unsigned) at full 24-bit signed width. Outputs update two cycles after the request strobe, that is, at the third clock edge counting from the one that samples the tick.
- R7: Control byte (`cfg_sel`=3) bit 7 enables the left output and bit 6 enables the right output. A disabled side receives 0 at the next output update.
- R8: Outputs hold their value between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Output-rate strobe, one cycle wide |
| start | input | 1 | Playback start strobe, clears the phase |
| cfg_we | input | 1 | Setting write enable |
| cfg_sel | input | 2 | Setting select: 0 step low, 1 step high, 2 volume, 3 control |
| cfg_data | input | 8 | Setting write data |
| prev_smp | input | 16 | Decoder's previous sample, signed |
| cur_smp | input | 16 | Decoder's current sample, signed |
| req_vld | output | 1 | Nibble request strobe |
| req_cnt | output | 1 | Number of nibbles to decode this tick |
| out_l | output | 24 | Left output, signed |
| out_r | output | 24 | Right output, signed |

## Verification
The assertions assume that `tick` and `start` are single-cycle strobes spaced at least three cycles apart, so that each interpolation and gain stage handles one tick at a time. They also assume that samples, volume and pan do not change while a tick travels through the pipeline. The stimulus keeps to this by issuing ticks four cycles apart from a task. It changes settings and samples only between tick sequences, with values drawn from a fixed-seed random stream, mixed with directed cases: zero step, maximum step, half step, zero and full volume, every pan combination, and a start that collides with a tick.

// File: rtl/rsi_pkg.sv
package rsi_pkg;
  typedef enum logic [1:0] {
    SEL_STEP_LO = 2'd0,
    SEL_STEP_HI = 2'd1,
    SEL_VOL     = 2'd2,
    SEL_CTRL    = 2'd3
  } cfg_sel_e;

  localparam int PAN_L_BIT = 7;
  localparam int PAN_R_BIT = 6;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsi_cfg.sv
module rsi_cfg
  import rsi_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [1:0]         sel,
  input  logic [CFG_W-1:0]   data,
  output logic [2*CFG_W-1:0] step,
  output logic [CFG_W-1:0]   vol,
  output logic               pan_l,
  output logic               pan_r
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= '0;
      vol   <= '0;
      pan_l <= 1'b1;
      pan_r <= 1'b1;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_STEP_LO: step[CFG_W-1:0]       <= data;
        SEL_STEP_HI: step[2*CFG_W-1:CFG_W] <= data;
        SEL_VOL:     vol                   <= data;
        SEL_CTRL: begin
          pan_l <= data[PAN_L_BIT];
          pan_r <= data[PAN_R_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsi_phase.sv
module rsi_phase #(
  parameter int FRAC_W = 16,
  parameter int STEP_W = 16,
  parameter int SUM_W  = 17,
  parameter int CNT_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [STEP_W-1:0] step,
  output logic [FRAC_W-1:0] phase_q,
  output logic              req_vld,
  output logic [CNT_W-1:0]  req_cnt
);
  logic [SUM_W-1:0] sum;

  assign sum = SUM_W'(phase_q) + SUM_W'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      req_vld <= 1'b0;
      req_cnt <= '0;
    end else if (start) begin
      phase_q <= '0;
      req_vld <= 1'b0;
    end else if (tick) begin
      phase_q <= sum[FRAC_W-1:0];
      req_vld <= 1'b1;
      req_cnt <= sum[SUM_W-1:FRAC_W];
    end else begin
      req_vld <= 1'b0;
    end
  end

  p_clear_on_start_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> (phase_q == '0) && !req_vld);

  p_req_follows_tick_r3: assert property (@(posedge clk) disable iff (rst)
    req_vld |-> $past(tick) && !$past(start));

  p_no_wrap_no_nibble_r3: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_cnt == '0) |-> phase_q >= $past(phase_q));
endmodule

// File: rtl/rsi_lerp.sv
module rsi_lerp #(
  parameter int SMP_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    start,
  input  logic [FRAC_W-1:0]       frac,
  input  logic signed [SMP_W-1:0] prev_smp,
  input  logic signed [SMP_W-1:0] cur_smp,
  output logic                    lerp_vld,
  output logic signed [SMP_W-1:0] lerp_q
);
  localparam int ACC_W = SMP_W + FRAC_W + 3;

  logic                    a_vld;
  logic [FRAC_W-1:0]       f_q;
  logic signed [SMP_W-1:0] p_q;
  logic signed [SMP_W-1:0] c_q;

  logic signed [ACC_W-1:0] p_ext, c_ext, wp_ext, wc_ext, acc;
  logic signed [SMP_W-1:0] lerp_d;

  always_comb begin
    p_ext  = ACC_W'(p_q);
    c_ext  = ACC_W'(c_q);
    wc_ext = $signed(ACC_W'(f_q));
    wp_ext = $signed((ACC_W'(1) <<< FRAC_W) - ACC_W'(f_q));
    acc    = p_ext * wp_ext + c_ext * wc_ext;
    lerp_d = SMP_W'(acc >>> FRAC_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld    <= 1'b0;
      f_q      <= '0;
      p_q      <= '0;
      c_q      <= '0;
      lerp_vld <= 1'b0;
      lerp_q   <= '0;
    end else begin
      a_vld    <= tick && !start;
      if (tick && !start) begin
        f_q <= frac;
        p_q <= prev_smp;
        c_q <= cur_smp;
      end
      lerp_vld <= a_vld;
      if (a_vld) lerp_q <= lerp_d;
    end
  end

  p_lerp_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    lerp_vld |->
      ((lerp_q >= $past(p_q) && lerp_q <= $past(c_q)) ||
       (lerp_q >= $past(c_q) && lerp_q <= $past(p_q))));

  p_lerp_zero_frac_r5: assert property (@(posedge clk) disable iff (rst)
    (lerp_vld && $past(f_q) == '0) |-> lerp_q == $past(p_q));
endmodule

// File: rtl/rsi_gain.sv
module rsi_gain #(
  parameter int SMP_W = 16,
  parameter int VOL_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_vld,
  input  logic signed [SMP_W-1:0]       in_smp,
  input  logic [VOL_W-1:0]              vol,
  input  logic                          pan_l,
  input  logic                          pan_r,
  output logic signed [SMP_W+VOL_W-1:0] out_l,
  output logic signed [SMP_W+VOL_W-1:0] out_r
);
  localparam int OUT_W = SMP_W + VOL_W;
  localparam int PRD_W = OUT_W + 1;

  logic signed [PRD_W-1:0] prod;
  logic signed [OUT_W-1:0] scaled;

  always_comb begin
    prod   = PRD_W'(in_smp) * $signed(PRD_W'(vol));
    scaled = OUT_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_l <= '0;
      out_r <= '0;
    end else if (in_vld) begin
      out_l <= pan_l ? scaled : '0;
      out_r <= pan_r ? scaled : '0;
    end
  end

  p_silent_at_zero_vol_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && vol == '0) |=> (out_l == '0) && (out_r == '0));

  p_hold_between_updates_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(in_vld) |-> $stable(out_l) && $stable(out_r));

  p_sides_agree_r7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && pan_l && pan_r) |=> out_l == out_r);
endmodule

// File: rtl/frac_rate_stepper.sv
module frac_rate_stepper
  import rsi_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int FRAC_W = 16,
  parameter int SMP_W  = 16,
  parameter int STEP_W = 2 * CFG_W,
  parameter int VOL_W  = CFG_W,
  parameter int SUM_W  = max_int(STEP_W, FRAC_W) + 1,
  parameter int CNT_W  = SUM_W - FRAC_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic                          start,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_sel,
  input  logic [CFG_W-1:0]              cfg_data,
  input  logic signed [SMP_W-1:0]       prev_smp,
  input  logic signed [SMP_W-1:0]       cur_smp,
  output logic                          req_vld,
  output logic [CNT_W-1:0]              req_cnt,
  output logic signed [SMP_W+VOL_W-1:0] out_l,
  output logic signed [SMP_W+VOL_W-1:0] out_r
);
  logic [STEP_W-1:0]       step;
  logic [VOL_W-1:0]        vol;
  logic                    pan_l, pan_r;
  logic [FRAC_W-1:0]       phase_q;
  logic                    lerp_vld;
  logic signed [SMP_W-1:0] lerp_q;

  rsi_cfg #(.CFG_W(CFG_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .step(step), .vol(vol), .pan_l(pan_l), .pan_r(pan_r)
  );

  rsi_phase #(.FRAC_W(FRAC_W), .STEP_W(STEP_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) phase_i (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .step(step),
    .phase_q(phase_q), .req_vld(req_vld), .req_cnt(req_cnt)
  );

  rsi_lerp #(.SMP_W(SMP_W), .FRAC_W(FRAC_W)) lerp_i (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .frac(phase_q),
    .prev_smp(prev_smp), .cur_smp(cur_smp),
    .lerp_vld(lerp_vld), .lerp_q(lerp_q)
  );

  rsi_gain #(.SMP_W(SMP_W), .VOL_W(VOL_W)) gain_i (
    .clk(clk), .rst(rst), .in_vld(lerp_vld), .in_smp(lerp_q), .vol(vol),
    .pan_l(pan_l), .pan_r(pan_r), .out_l(out_l), .out_r(out_r)
  );
endmodule

// File: tb/frac_rate_stepper_tb_top.sv
module frac_rate_stepper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_data = 8'd0;
  logic signed [15:0] prev_smp = '0;
  logic signed [15:0] cur_smp = '0;
  logic        req_vld;
  logic [0:0]  req_cnt;
  logic signed [23:0] out_l, out_r;

  int n_chk = 0;
  int n_bad = 0;

  longint m_phase = 0, m_step = 0, m_vol = 0;
  bit     m_pl = 1, m_pr = 1;
  longint exp_l = 0, exp_r = 0;

  always #4 clk = ~clk;

  frac_rate_stepper dut_i (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .prev_smp(prev_smp), .cur_smp(cur_smp),
    .req_vld(req_vld), .req_cnt(req_cnt), .out_l(out_l), .out_r(out_r)
  );

  function automatic longint lerp_model(longint p, longint c, longint f);
    longint a;
    a = p * (65536 - f) + c * f;
    return a >>> 16;
  endfunction

  task automatic check(string req, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      2'd0: m_step = (m_step & 64'hFF00) | longint'(d);
      2'd1: m_step = (m_step & 64'h00FF) | (longint'(d) << 8);
      2'd2: m_vol  = longint'(d);
      default: begin m_pl = d[7]; m_pr = d[6]; end
    endcase
  endtask

  task automatic set_step(input logic [15:0] s);
    wr(2'd0, s[7:0]);
    wr(2'd1, s[15:8]);
  endtask

  // one tick with given samples; checks request and outputs
  task automatic do_tick(input logic signed [15:0] p, input logic signed [15:0] c, string tag);
    longint sum, f, g;
    @(negedge clk);
    prev_smp = p; cur_smp = c; tick = 1'b1;
    f = m_phase;
    sum = m_phase + m_step;
    m_phase = sum & 64'hFFFF;
    @(negedge clk);
    tick = 1'b0;
    check({"R3 req_vld ", tag}, longint'(req_vld), 1);
    check({"R3 req_cnt ", tag}, longint'(req_cnt), sum >> 16);
    @(negedge clk);
    check({"R3 strobe one cycle ", tag}, longint'(req_vld), 0);
    @(negedge clk);
    g = lerp_model(longint'(p), longint'(c), f) * m_vol;
    exp_l = m_pl ? g : 0;
    exp_r = m_pr ? g : 0;
    check({"R5/R6/R7 out_l ", tag}, longint'(out_l), exp_l);
    check({"R5/R6/R7 out_r ", tag}, longint'(out_r), exp_r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 req_vld", longint'(req_vld), 0);
    check("R1 out_l", longint'(out_l), 0);
    check("R1 out_r", longint'(out_r), 0);
    // R1: step 0 and vol 0 after reset -> no nibble, silent
    do_tick(16'sd1000, 16'sd2000, "R1 defaults");

    // R2/R3 half step: phase alternates 0x8000/0
    wr(2'd2, 8'd255);
    set_step(16'h8000);
    do_tick(16'sd100, 16'sd300, "R2 half a");
    do_tick(-16'sd32768, 16'sd32767, "R2 half b");
    do_tick(16'sd32767, -16'sd32768, "R2 half c");

    // max step, extremes
    set_step(16'hFFFF);
    for (int i = 0; i < 4; i++) do_tick(-16'sd32768, -16'sd32768, "R6 max neg");

    // R7 every pan combination
    for (int k = 0; k < 4; k++) begin
      wr(2'd3, {k[1:0], 6'h2A});
      do_tick(16'sd12345, -16'sd2345, "R7 pan");
    end
    wr(2'd3, 8'hC0);

    // R4 start clears phase -> next tick uses frac 0
    set_step(16'h3001);
    do_tick(16'sd500, 16'sd700, "R4 pre");
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    m_phase = 0;
    do_tick(16'sd500, 16'sd700, "R4 after start");

    // R4 start colliding with tick: no request, outputs hold (R8)
    @(negedge clk); start = 1'b1; tick = 1'b1; prev_smp = 16'sd9; cur_smp = 16'sd9;
    @(negedge clk); start = 1'b0; tick = 1'b0;
    m_phase = 0;
    check("R4 no req on collision", longint'(req_vld), 0);
    repeat (3) @(negedge clk);
    check("R8 hold out_l", longint'(out_l), exp_l);
    check("R8 hold out_r", longint'(out_r), exp_r);
    do_tick(16'sd40, -16'sd40, "R4 after collision");

    // step 0: never consumes, frac stays
    set_step(16'h0000);
    do_tick(16'sd7, 16'sd9, "R3 zero step");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) set_step(r[31:16]);
      if (r[7:4] == 4'd0) wr(2'd2, r[15:8]);
      if (r[11:8] == 4'd0) wr(2'd3, r[23:16]);
      if (r[15:12] == 4'd0) begin
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        m_phase = 0;
      end
      do_tick($signed(16'($urandom)), $signed(16'($urandom)), "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule